// File: doc/BRIEF.md
# One-Hot Serial Receive Sequencer

This block is the control part of a serial receiver whose clock already runs at one tick per bit period. It rests in an idle state until the receive line is seen low. A small set/reset flag records that start condition. On the clock edge after the flag is set, the block leaves idle and walks a token through a chain of one-hot state flops: one state per data bit, an optional parity state, a latch state and a strobe state. It then drops back to idle.

Every state flop drives its own output pin directly. A neighbouring datapath uses the data-bit states to shift in the received bits. It uses the latch state to copy its shift register into an output buffer, and it treats the one-cycle strobe as "new character available". Two parameters shorten the chain: a seven-bit character skips the last data state, and a frame without parity skips the parity state. The error pin is present for interface compatibility and is held low.

Top module: `uart_rx_onehot_seq`

## Requirements
- R1: While `rst_n` is low, `idle` is 1, `busy` is 0 and every other state output (`data_state`, `parity_state`, `latch_state`, `strobe_state`) is 0.
- R2: After reset, exactly one of the twelve state outputs is high in every cycle, and `busy` is always the inverse of `idle`.
- R3: When `rx_line` is sampled low at a rising edge while `idle` is 1, the start flag is set and `idle` stays high for that cycle. On the next rising edge `idle` goes to 0 and `data_state[0]` goes to 1.
- R4: While `idle` is 1 and `rx_line` is sampled high, the block stays in idle.
- R5: After `data_state[0]`, bit i of `data_state` (data state Di) is high on each following clock for i = 1 up to DATA_BITS-1. Then `parity_state` (when PARITY_EN is 1), `latch_state` and `strobe_state` follow, each high for exactly one clock.
- R6: One clock after `strobe_state` the block is back in idle. A receive line that is still low then starts a new frame with the same timing as R3.
- R7: `rx_line` has no effect while `busy` is 1, and the start flag is cleared in the latch state. A line that went low during a frame does not start a new frame once idle is re-entered with the line high.
- R8: `error` is 0 at all times.
- R9: With DATA_BITS = 7, `data_state[7]` is never high and `latch_state` or `parity_state` follows `data_state[6]`. With PARITY_EN = 0, `parity_state` is never high and `latch_state` follows the last data state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial receive line, low marks a start condition |
| idle | output | 1 | High while waiting for a frame |
| busy | output | 1 | Inverse of idle |
| data_state | output | 8 | Bit i high while data bit i is being received |
| parity_state | output | 1 | High during the parity bit period |
| latch_state | output | 1 | High for one clock: copy the shift register to the buffer |
| strobe_state | output | 1 | One-clock pulse: new character available |
| error | output | 1 | Always low |

## Verification
A full eight-bit frame with parity is walked with the receive line toggling during the frame. This separates a chain that ignores the line from one that restarts or stalls on it. The check that idle is held afterwards shows whether the start flag was really cleared. A line held low across the strobe checks that a new frame begins with the normal one-cycle capture delay and not immediately. A second instance built for seven bits without parity shows that both bypasses route the token past the unused states. A reset asserted mid-frame shows the asynchronous return to idle.

// File: rtl/uart_seq_pkg.sv
package uart_seq_pkg;
  localparam int MAX_DATA = 8;
  localparam int NST      = MAX_DATA + 4;
  localparam int IDX_IDLE = 0;
  localparam int IDX_D0   = 1;
  localparam int IDX_PAR  = MAX_DATA + 1;
  localparam int IDX_LAT  = MAX_DATA + 2;
  localparam int IDX_STB  = MAX_DATA + 3;

  // index of the last data state for a given character width
  function automatic int last_data_idx(input int data_bits);
    return IDX_D0 + data_bits - 1;
  endfunction

  // clocks spent outside idle for one frame
  function automatic int frame_len(input int data_bits, input bit par_en);
    return data_bits + (par_en ? 1 : 0) + 2;
  endfunction
endpackage

// File: rtl/uart_start_detect.sv
module uart_start_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  input  logic in_idle,
  input  logic in_latch,
  output logic start_q
);
  logic set_evt;
  logic clr_evt;

  assign set_evt = in_idle & ~rx_line;
  assign clr_evt = in_latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       start_q <= 1'b0;
    else if (clr_evt) start_q <= 1'b0;
    else if (set_evt) start_q <= 1'b1;
  end

  // R7: flag is cleared after the latch state
  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_latch |=> !start_q);
  // R7: line is ignored while busy
  assert_no_set_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_idle && !start_q) |=> !start_q);
endmodule

// File: rtl/uart_onehot_chain.sv
module uart_onehot_chain
  import uart_seq_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter bit PARITY_EN = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_q,
  output logic [NST-1:0] st
);
  localparam int LAST_D = last_data_idx(DATA_BITS);
  localparam logic [NST-1:0] RESET_ST = NST'(1) << IDX_IDLE;

  logic [NST-1:0] nxt;
  logic           frame_begin;
  logic           frame_end;

  assign frame_begin = st[IDX_IDLE] & start_q;
  assign frame_end   = st[IDX_STB];

  always_comb begin
    nxt           = '0;
    nxt[IDX_IDLE] = (st[IDX_IDLE] & ~start_q) | frame_end;
    nxt[IDX_D0]   = frame_begin;
    nxt[IDX_LAT]  = PARITY_EN ? st[IDX_PAR] : st[LAST_D];
    nxt[IDX_STB]  = st[IDX_LAT];
    if (PARITY_EN) nxt[IDX_PAR] = st[LAST_D];
  end

  // data chain: only the states in use get a predecessor
  logic [MAX_DATA-1:0] data_nxt;
  assign data_nxt[0] = nxt[IDX_D0];
  for (genvar i = 1; i < MAX_DATA; i++) begin : g_data
    if (i < DATA_BITS) begin : g_used
      assign data_nxt[i] = st[IDX_D0 + i - 1];
    end else begin : g_skip
      assign data_nxt[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= RESET_ST;
    else        st <= {nxt[NST-1:IDX_PAR], data_nxt, nxt[IDX_IDLE]};
  end

  initial assert (DATA_BITS == 7 || DATA_BITS == 8);

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st) == 1);
  assert_enter_d0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_begin |=> (st[IDX_D0] && !st[IDX_IDLE]));
  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st[IDX_IDLE] && !start_q) |=> st[IDX_IDLE]);
  assert_latch_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st[IDX_LAT] |=> st[IDX_STB]);
  assert_return_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> st[IDX_IDLE]);
  assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st[LAST_D] |=> (PARITY_EN ? st[IDX_PAR] : st[IDX_LAT]));
endmodule

// File: rtl/uart_rx_onehot_seq.sv
module uart_rx_onehot_seq
  import uart_seq_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter bit PARITY_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  output logic       idle,
  output logic       busy,
  output logic [7:0] data_state,
  output logic       parity_state,
  output logic       latch_state,
  output logic       strobe_state,
  output logic       error
);
  logic [NST-1:0] st;
  logic           start_q;

  uart_start_detect u_start (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_line  (rx_line),
    .in_idle  (st[IDX_IDLE]),
    .in_latch (st[IDX_LAT]),
    .start_q  (start_q)
  );

  uart_onehot_chain #(
    .DATA_BITS (DATA_BITS),
    .PARITY_EN (PARITY_EN)
  ) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_q (start_q),
    .st      (st)
  );

  assign idle         = st[IDX_IDLE];
  assign busy         = ~st[IDX_IDLE];
  assign data_state   = st[IDX_D0 +: MAX_DATA];
  assign parity_state = st[IDX_PAR];
  assign latch_state  = st[IDX_LAT];
  assign strobe_state = st[IDX_STB];
  assign error        = 1'b0;

  assert_busy_inv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy != idle);
endmodule

// File: tb/uart_rx_onehot_seq_tb.sv
module uart_rx_onehot_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic rx7 = 1'b1;
  int   tests = 0;
  int   fails = 0;

  always #2 clk = ~clk;

  logic idle, busy, par, lat, stb, err;
  logic [7:0] dat;
  logic idle7, busy7, par7, lat7, stb7, err7;
  logic [7:0] dat7;

  uart_rx_onehot_seq u_dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx), .idle(idle), .busy(busy),
    .data_state(dat), .parity_state(par), .latch_state(lat),
    .strobe_state(stb), .error(err));

  uart_rx_onehot_seq #(.DATA_BITS(7), .PARITY_EN(1'b0)) u_dut7 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx7), .idle(idle7), .busy(busy7),
    .data_state(dat7), .parity_state(par7), .latch_state(lat7),
    .strobe_state(stb7), .error(err7));

  // packing: bit0 idle, bits1..8 data 0..7, bit9 parity, bit10 latch, bit11 strobe
  wire [11:0] cur  = {stb, lat, par, dat, idle};
  wire [11:0] cur7 = {stb7, lat7, par7, dat7, idle7};

  // {rx, expected state after the edge, requirement number}
  localparam int NV = 16;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 12'h001, 4'd4}, {1'b1, 12'h001, 4'd4},
    {1'b0, 12'h001, 4'd3}, {1'b1, 12'h002, 4'd3},
    {1'b0, 12'h004, 4'd7}, {1'b1, 12'h008, 4'd5},
    {1'b0, 12'h010, 4'd7}, {1'b0, 12'h020, 4'd5},
    {1'b1, 12'h040, 4'd5}, {1'b0, 12'h080, 4'd7},
    {1'b1, 12'h100, 4'd5}, {1'b0, 12'h200, 4'd5},
    {1'b0, 12'h400, 4'd5}, {1'b1, 12'h800, 4'd5},
    {1'b1, 12'h001, 4'd6}, {1'b1, 12'h001, 4'd7}};

  function automatic string tag(input int n);
    case (n)
      1: return "R1"; 2: return "R2"; 3: return "R3";
      4: return "R4"; 5: return "R5"; 6: return "R6";
      7: return "R7"; 8: return "R8"; default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic b);
    @(negedge clk);
    rx  = a;
    rx7 = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #9;
    check("R1", cur, 12'h001);
    check("R1", {11'd0, busy}, 12'h000);
    check("R1", cur7, 12'h001);
    @(negedge clk); rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][16], 1'b1);
      check(tag(int'(VEC[k][3:0])), cur, VEC[k][15:4]);
      check("R2", {11'd0, busy}, {11'd0, ~VEC[k][4]});
      check("R8", {11'd0, err}, 12'h000);
    end

    // R6: line held low across the strobe restarts with normal delay
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    check("R3", cur, 12'h002);
    for (int k = 0; k < 11; k++) step(1'b0, 1'b1);
    check("R6", cur, 12'h001);
    step(1'b0, 1'b1);
    check("R6", cur, 12'h001);
    step(1'b0, 1'b1);
    check("R6", cur, 12'h002);

    // R1: asynchronous reset mid-frame
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    check("R5", cur, 12'h008);
    #1 rst_n = 1'b0;
    #1;
    check("R1", cur, 12'h001);
    @(negedge clk); rst_n = 1'b1;
    step(1'b1, 1'b1);
    check("R4", cur, 12'h001);

    // R9: seven data bits, no parity
    step(1'b1, 1'b0);
    check("R3", cur7, 12'h001);
    step(1'b1, 1'b1);
    for (int i = 0; i < 7; i++) begin
      check("R9", cur7, 12'(1) << (i + 1));
      step(1'b1, 1'b1);
    end
    check("R9", cur7, 12'h400);
    step(1'b1, 1'b1);
    check("R9", cur7, 12'h800);
    step(1'b1, 1'b1);
    check("R9", cur7, 12'h001);
    check("R8", {11'd0, err7}, 12'h000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule